// File: doc/BRIEF.md
# Banked General Register File

This block stores the architectural registers of a 32-bit processor core: sixteen general registers and two sixteen-entry floating-point banks. The lower eight general registers have two physical copies. Which copy is visible depends on two status bits held inside the block, a privilege-mode bit and a bank-select bit. The upper eight general registers have one copy only. A single control bit picks which floating-point bank is visible.

The core reads two general registers and one floating-point register per cycle and writes one of each. It updates the mode and bank bits through a status-write strobe, and the floating-point bank bit through a control-write strobe. A debug port takes a signed index. Through it a debugger can read the visible registers or either physical copy of the banked registers, whichever copy is active at the time.

All read results are registered. They appear one cycle after the index is presented and show the state after that clock edge, including any write or bank change made in the same cycle.

Top module: `bank_regfile`

## Requirements
- R1: General registers 8 to 15 have one copy. A write to one of them is seen by later reads under every bank setting. Registers 0 to 7 have one copy per bank.
- R2: On a cycle with `sr_wr_en` high, bank 1 becomes the visible integer bank if `sr_md` and `sr_rb` are both 1. Any other combination makes bank 0 visible. Without `sr_wr_en` the selection holds.
- R3: Changing the visible integer bank swaps the visible and hidden copies of registers 0 to 7. Both copies keep their contents, and switching back shows the earlier values again.
- R4: On a cycle with `fpc_wr_en` high, `fpc_fr` selects the visible floating-point bank (0 or 1). A write that leaves the bit unchanged changes no visible value.
- R5: Debug indices map as follows, with `dbg_valid` 1 one cycle later:
  - 0 to 15: the visible general registers.
  - 25 to 40: the visible floating-point registers 0 to 15.
  - 43 to 50: physical bank 0 registers 0 to 7.
  - 51 to 58: physical bank 1 registers 0 to 7.
- R6: Any other debug index gives `dbg_valid` 0 and `dbg_data` 0 one cycle later. This covers negative indices (bit 7 set), indices of 94 and above, and the gaps between the mapped ranges.
- R7: After reset, every register in every bank reads 0, integer bank 0 is visible, and floating-point bank 0 is visible.
- R8: Read data is registered with one cycle of latency. A read of a register written in the same cycle returns the new value.
- R9: A register write in the same cycle as a bank change lands in the bank that is visible after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | General register write strobe |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 32 | General register write data |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data (registered) |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data (registered) |
| fp_wr_en | input | 1 | Floating-point write strobe |
| fp_wr_idx | input | 4 | Floating-point write index |
| fp_wr_data | input | 32 | Floating-point write data |
| fp_rd_idx | input | 4 | Floating-point read index |
| fp_rd_data | output | 32 | Floating-point read data (registered) |
| sr_wr_en | input | 1 | Status write strobe for mode and bank bits |
| sr_md | input | 1 | Privilege-mode bit |
| sr_rb | input | 1 | Integer bank-select bit |
| fpc_wr_en | input | 1 | Floating-point control write strobe |
| fpc_fr | input | 1 | Floating-point bank-select bit |
| dbg_idx | input | 8 | Debug index, two's complement |
| dbg_valid | output | 1 | Debug index was mapped |
| dbg_data | output | 32 | Debug read data |

## Verification
The assertions assume the inputs carry known values on every clock edge outside reset. The bypass and debug properties compare registered outputs against the inputs one cycle earlier, so an unknown index would make them meaningless. The bench holds every strobe low and parks every index at a defined value between operations. It drives signed debug indices only in the 8-bit range, so negative values reach the block as two's-complement patterns with bit 7 set.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int DBG_FPR_BASE = 25;
  localparam int DBG_BK0_BASE = 43;
  localparam int DBG_BK1_BASE = 51;
  localparam int DBG_LIMIT    = 94;

  typedef enum logic [1:0] {
    DK_NONE = 2'd0,
    DK_GPR  = 2'd1,
    DK_FPR  = 2'd2
  } dbg_kind_e;
endpackage

// File: rtl/brf_mode_ctrl.sv
module brf_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sr_wr_en,
  input  logic sr_md,
  input  logic sr_rb,
  input  logic fpc_wr_en,
  input  logic fpc_fr,
  output logic gsel_nxt,
  output logic fsel_nxt
);
  logic gsel_q;
  logic fsel_q;

  // Bank 1 is visible only with mode and bank bits both set (R2)
  assign gsel_nxt = sr_wr_en  ? (sr_md & sr_rb) : gsel_q;
  assign fsel_nxt = fpc_wr_en ? fpc_fr          : fsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gsel_q <= 1'b0;
      fsel_q <= 1'b0;
    end else begin
      gsel_q <= gsel_nxt;
      fsel_q <= fsel_nxt;
    end
  end
endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store #(
  parameter int XLEN    = 32,
  parameter int NGPR    = 16,
  parameter int NBANKED = 8,
  parameter int NRP     = 3,
  localparam int IW = $clog2(NGPR),
  localparam int BW = $clog2(NBANKED),
  localparam int SW = $clog2(NGPR - NBANKED)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     gsel_nxt,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [NRP-1:0]           rd_phys,
  input  logic [NRP-1:0]           rd_bank,
  input  logic [NRP-1:0][IW-1:0]   rd_idx,
  output logic [NRP-1:0][XLEN-1:0] rd_data
);
  logic [XLEN-1:0] bnk_q [2][NBANKED];
  logic [XLEN-1:0] bnk_n [2][NBANKED];
  logic [XLEN-1:0] shr_q [NGPR-NBANKED];
  logic [XLEN-1:0] shr_n [NGPR-NBANKED];
  logic [IW-1:0]   wofs;

  assign wofs = wr_idx - IW'(NBANKED);

  // Next state: write lands in the bank visible after any swap (R9)
  always_comb begin
    bnk_n = bnk_q;
    shr_n = shr_q;
    if (wr_en) begin
      if (wr_idx < IW'(NBANKED)) bnk_n[gsel_nxt][wr_idx[BW-1:0]] = wr_data;
      else                       shr_n[wofs[SW-1:0]] = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NBANKED; i++) bnk_q[b][i] <= '0;
      for (int i = 0; i < NGPR - NBANKED; i++) shr_q[i] <= '0;
    end else begin
      bnk_q <= bnk_n;
      shr_q <= shr_n;
    end
  end

  // Registered read ports see the post-edge state (write-first, R8)
  for (genvar p = 0; p < NRP; p++) begin : g_rd
    logic [IW-1:0]   ofs;
    logic            bsel;
    logic [XLEN-1:0] q;
    assign ofs  = rd_idx[p] - IW'(NBANKED);
    assign bsel = rd_phys[p] ? rd_bank[p] : gsel_nxt;
    always_ff @(posedge clk) begin
      if (rst)                          q <= '0;
      else if (rd_idx[p] < IW'(NBANKED)) q <= bnk_n[bsel][rd_idx[p][BW-1:0]];
      else                              q <= shr_n[ofs[SW-1:0]];
    end
    assign rd_data[p] = q;
  end
endmodule

// File: rtl/brf_fpr_store.sv
module brf_fpr_store #(
  parameter int XLEN = 32,
  parameter int NFPR = 16,
  parameter int NRP  = 2,
  localparam int FW = $clog2(NFPR)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fsel_nxt,
  input  logic                     wr_en,
  input  logic [FW-1:0]            wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [NRP-1:0][FW-1:0]   rd_idx,
  output logic [NRP-1:0][XLEN-1:0] rd_data
);
  logic [XLEN-1:0] fr_q [2][NFPR];
  logic [XLEN-1:0] fr_n [2][NFPR];

  always_comb begin
    fr_n = fr_q;
    if (wr_en) fr_n[fsel_nxt][wr_idx] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NFPR; i++) fr_q[b][i] <= '0;
    end else begin
      fr_q <= fr_n;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= fr_n[fsel_nxt][rd_idx[p]];
    end
    assign rd_data[p] = q;
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int XLEN    = 32,
  parameter int NGPR    = 16,
  parameter int NBANKED = 8,
  parameter int NFPR    = 16,
  parameter int DW      = 8,
  localparam int IW = $clog2(NGPR),
  localparam int FW = $clog2(NFPR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IW-1:0]   rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [IW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            fp_wr_en,
  input  logic [FW-1:0]   fp_wr_idx,
  input  logic [XLEN-1:0] fp_wr_data,
  input  logic [FW-1:0]   fp_rd_idx,
  output logic [XLEN-1:0] fp_rd_data,
  input  logic            sr_wr_en,
  input  logic            sr_md,
  input  logic            sr_rb,
  input  logic            fpc_wr_en,
  input  logic            fpc_fr,
  input  logic [DW-1:0]   dbg_idx,
  output logic            dbg_valid,
  output logic [XLEN-1:0] dbg_data
);
  import brf_pkg::*;

  localparam int GRP = 3;  // read A, read B, debug
  localparam int FRP = 2;  // fp read, debug

  logic gsel_nxt, fsel_nxt;

  brf_mode_ctrl u_mode (
    .clk(clk), .rst(rst),
    .sr_wr_en(sr_wr_en), .sr_md(sr_md), .sr_rb(sr_rb),
    .fpc_wr_en(fpc_wr_en), .fpc_fr(fpc_fr),
    .gsel_nxt(gsel_nxt), .fsel_nxt(fsel_nxt)
  );

  // Debug index decode
  dbg_kind_e     kind_d, kind_q;
  logic          dg_phys, dg_bank;
  logic [IW-1:0] dg_idx;
  logic [FW-1:0] df_idx;

  always_comb begin
    kind_d  = DK_NONE;
    dg_phys = 1'b0;
    dg_bank = 1'b0;
    dg_idx  = '0;
    df_idx  = '0;
    if (!dbg_idx[DW-1] && dbg_idx < DW'(DBG_LIMIT)) begin
      if (dbg_idx < DW'(NGPR)) begin
        kind_d = DK_GPR;
        dg_idx = IW'(dbg_idx);
      end else if (dbg_idx >= DW'(DBG_FPR_BASE) && dbg_idx < DW'(DBG_FPR_BASE + NFPR)) begin
        kind_d = DK_FPR;
        df_idx = FW'(dbg_idx - DW'(DBG_FPR_BASE));
      end else if (dbg_idx >= DW'(DBG_BK0_BASE) && dbg_idx < DW'(DBG_BK0_BASE + NBANKED)) begin
        kind_d  = DK_GPR;
        dg_phys = 1'b1;
        dg_bank = 1'b0;
        dg_idx  = IW'(dbg_idx - DW'(DBG_BK0_BASE));
      end else if (dbg_idx >= DW'(DBG_BK1_BASE) && dbg_idx < DW'(DBG_BK1_BASE + NBANKED)) begin
        kind_d  = DK_GPR;
        dg_phys = 1'b1;
        dg_bank = 1'b1;
        dg_idx  = IW'(dbg_idx - DW'(DBG_BK1_BASE));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) kind_q <= DK_NONE;
    else     kind_q <= kind_d;
  end

  logic [GRP-1:0][XLEN-1:0] g_rdata;
  logic [FRP-1:0][XLEN-1:0] f_rdata;

  brf_gpr_store #(.XLEN(XLEN), .NGPR(NGPR), .NBANKED(NBANKED), .NRP(GRP)) u_gpr (
    .clk(clk), .rst(rst), .gsel_nxt(gsel_nxt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_phys({dg_phys, 1'b0, 1'b0}),
    .rd_bank({dg_bank, 1'b0, 1'b0}),
    .rd_idx({dg_idx, rd_b_idx, rd_a_idx}),
    .rd_data(g_rdata)
  );

  brf_fpr_store #(.XLEN(XLEN), .NFPR(NFPR), .NRP(FRP)) u_fpr (
    .clk(clk), .rst(rst), .fsel_nxt(fsel_nxt),
    .wr_en(fp_wr_en), .wr_idx(fp_wr_idx), .wr_data(fp_wr_data),
    .rd_idx({df_idx, fp_rd_idx}),
    .rd_data(f_rdata)
  );

  assign rd_a_data  = g_rdata[0];
  assign rd_b_data  = g_rdata[1];
  assign fp_rd_data = f_rdata[0];
  assign dbg_valid  = (kind_q != DK_NONE);
  assign dbg_data   = (kind_q == DK_GPR) ? g_rdata[2] :
                      (kind_q == DK_FPR) ? f_rdata[1] : '0;
endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int XLEN = 32,
  parameter int IW   = 4,
  parameter int FW   = 4,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [IW-1:0]   wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic [IW-1:0]   rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic [IW-1:0]   rd_b_idx,
  input logic [XLEN-1:0] rd_b_data,
  input logic            fp_wr_en,
  input logic [FW-1:0]   fp_wr_idx,
  input logic [XLEN-1:0] fp_wr_data,
  input logic [FW-1:0]   fp_rd_idx,
  input logic [XLEN-1:0] fp_rd_data,
  input logic [DW-1:0]   dbg_idx,
  input logic            dbg_valid,
  input logic [XLEN-1:0] dbg_data
);
  logic pv;
  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b0;
    else     pv <= 1'b1;
  end

  a_r8_bypass_a: assert property (@(posedge clk) disable iff (rst)
    pv && $past(wr_en && wr_idx == rd_a_idx) |-> rd_a_data == $past(wr_data));

  a_r8_bypass_b: assert property (@(posedge clk) disable iff (rst)
    pv && $past(wr_en && wr_idx == rd_b_idx) |-> rd_b_data == $past(wr_data));

  a_r8_bypass_fp: assert property (@(posedge clk) disable iff (rst)
    pv && $past(fp_wr_en && fp_wr_idx == fp_rd_idx) |-> fp_rd_data == $past(fp_wr_data));

  a_r6_bad_dbg: assert property (@(posedge clk) disable iff (rst)
    pv && $past(dbg_idx[DW-1] || dbg_idx >= DW'(brf_pkg::DBG_LIMIT))
      |-> (!dbg_valid && dbg_data == '0));

  a_r5_dbg_visible: assert property (@(posedge clk) disable iff (rst)
    pv && $past(!dbg_idx[DW-1] && dbg_idx < DW'(16)) |-> dbg_valid);

  a_r7_reset_clear: assert property (@(posedge clk)
    pv && $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0 && !dbg_valid));
endmodule

bind bank_regfile brf_checker #(.XLEN(XLEN), .IW(IW), .FW(FW), .DW(DW)) u_chk (.*);

// File: tb/bank_regfile_bench.sv
`timescale 1ns/1ps
module bank_regfile_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, fp_wr_en, sr_wr_en, sr_md, sr_rb, fpc_wr_en, fpc_fr;
  logic [3:0]  wr_idx, rd_a_idx, rd_b_idx, fp_wr_idx, fp_rd_idx;
  logic [31:0] wr_data, fp_wr_data, rd_a_data, rd_b_data, fp_rd_data, dbg_data;
  logic [7:0]  dbg_idx;
  logic        dbg_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bank_regfile u_bank_regfile (.*);

  typedef struct packed {
    logic        we;
    logic [3:0]  wi;
    logic [31:0] wd;
    logic [3:0]  ri;
    logic [31:0] ex;
  } vec_t;

  // Bank 0 visible throughout; covers R8 bypass and R1 shared registers
  localparam vec_t VECS [8] = '{
    '{1'b1, 4'd0,  32'h1111_1111, 4'd0,  32'h1111_1111},
    '{1'b1, 4'd7,  32'h0000_0077, 4'd0,  32'h1111_1111},
    '{1'b1, 4'd8,  32'h0000_0088, 4'd7,  32'h0000_0077},
    '{1'b1, 4'd15, 32'h0000_00FF, 4'd8,  32'h0000_0088},
    '{1'b0, 4'd0,  32'h0,         4'd15, 32'h0000_00FF},
    '{1'b1, 4'd0,  32'h0000_0022, 4'd0,  32'h0000_0022},
    '{1'b1, 4'd9,  32'h0000_0099, 4'd1,  32'h0},
    '{1'b0, 4'd0,  32'h0,         4'd9,  32'h0000_0099}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    wr_en = 1'b0; fp_wr_en = 1'b0; sr_wr_en = 1'b0; fpc_wr_en = 1'b0;
  endtask

  task automatic set_sr(input logic md, input logic rb);
    sr_wr_en = 1'b1; sr_md = md; sr_rb = rb;
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; fp_wr_en = 0; sr_wr_en = 0; fpc_wr_en = 0;
    sr_md = 0; sr_rb = 0; fpc_fr = 0;
    wr_idx = 0; wr_data = 0; rd_a_idx = 0; rd_b_idx = 0;
    fp_wr_idx = 0; fp_wr_data = 0; fp_rd_idx = 0; dbg_idx = 8'd100;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk("R7 reset rd_a", rd_a_data, 32'h0);
    chk("R7 reset dbg_valid", {31'b0, dbg_valid}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      wr_en = VECS[i].we; wr_idx = VECS[i].wi; wr_data = VECS[i].wd;
      rd_a_idx = VECS[i].ri;
      cyc();
      chk("R8 vector read", rd_a_data, VECS[i].ex);
    end

    // R2: mode set without bank bit keeps bank 0
    set_sr(1'b1, 1'b0); rd_a_idx = 4'd0; cyc();
    chk("R2 md only keeps bank0", rd_a_data, 32'h22);
    // R2/R3: both bits set -> bank 1 visible, fresh copy
    set_sr(1'b1, 1'b1); rd_b_idx = 4'd8; cyc();
    chk("R3 bank1 R0 empty", rd_a_data, 32'h0);
    chk("R1 shared R8 in bank1", rd_b_data, 32'h88);
    wr_en = 1; wr_idx = 4'd0; wr_data = 32'hAA; cyc();
    dbg_idx = 8'd43; cyc();
    chk("R5 dbg bank0 R0", dbg_data, 32'h22);
    chk("R5 dbg valid", {31'b0, dbg_valid}, 32'h1);
    dbg_idx = 8'd51; cyc();
    chk("R5 dbg bank1 R0", dbg_data, 32'hAA);
    // R2: bank bit without mode -> bank 0
    set_sr(1'b0, 1'b1); dbg_idx = 8'd0; cyc();
    chk("R2 rb only gives bank0", rd_a_data, 32'h22);
    chk("R5 dbg visible R0", dbg_data, 32'h22);
    dbg_idx = 8'd51; cyc();
    chk("R3 bank1 copy kept", dbg_data, 32'hAA);

    // R9: write in the swap cycle lands in the new bank
    set_sr(1'b1, 1'b1); wr_en = 1; wr_idx = 4'd1; wr_data = 32'hBB; rd_a_idx = 4'd1; cyc();
    chk("R9 write with swap", rd_a_data, 32'hBB);
    set_sr(1'b0, 1'b0); dbg_idx = 8'd52; cyc();
    chk("R9 bank0 R1 untouched", rd_a_data, 32'h0);
    chk("R9 dbg bank1 R1", dbg_data, 32'hBB);

    // R4 floating-point banks
    fp_wr_en = 1; fp_wr_idx = 4'd2; fp_wr_data = 32'hF2; fp_rd_idx = 4'd2; cyc();
    chk("R8 fp bypass", fp_rd_data, 32'hF2);
    fpc_wr_en = 1; fpc_fr = 1; cyc();
    chk("R4 fp bank1 empty", fp_rd_data, 32'h0);
    fp_wr_en = 1; fp_wr_idx = 4'd2; fp_wr_data = 32'hE2; cyc();
    fpc_wr_en = 1; fpc_fr = 0; dbg_idx = 8'd27; cyc();
    chk("R4 fp bank0 back", fp_rd_data, 32'hF2);
    chk("R5 dbg fp visible", dbg_data, 32'hF2);
    fpc_wr_en = 1; fpc_fr = 0; cyc();
    chk("R4 same bit no change", fp_rd_data, 32'hF2);

    // R6 unmapped indices
    dbg_idx = 8'hFF; cyc();
    chk("R6 negative valid", {31'b0, dbg_valid}, 32'h0);
    chk("R6 negative data", dbg_data, 32'h0);
    dbg_idx = 8'd94; cyc();
    chk("R6 index 94 valid", {31'b0, dbg_valid}, 32'h0);
    dbg_idx = 8'd20; cyc();
    chk("R6 gap index data", dbg_data, 32'h0);

    // R7 reset clears all banks and selects bank 0
    set_sr(1'b1, 1'b1); cyc();
    rst = 1'b1; cyc(); cyc();
    rst = 1'b0; rd_a_idx = 4'd9; dbg_idx = 8'd52; cyc();
    chk("R7 shared cleared", rd_a_data, 32'h0);
    chk("R7 bank1 cleared", dbg_data, 32'h0);
    wr_en = 1; wr_idx = 4'd3; wr_data = 32'h33; dbg_idx = 8'd46; cyc();
    chk("R7 bank0 active after reset", dbg_data, 32'h33);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #80000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule